// File: doc/BRIEF.md
# DMA Channel Register Block

This block is the control and status register file for one channel of a descriptor-driven DMA engine. A 32-bit, word-only bus reaches it. It stores the descriptor pointers, the configuration, command and stream-command words, and the interrupt mask. It tracks the channel run state and an end-of-list flag, and it builds the status word from those live values on each read. The block does not move data. Instead it sends single-cycle request pulses to a separate descriptor engine: load a data descriptor, load a context, or continue after end of list. In return it takes interrupt-set and end-of-list events from that engine.

Each channel decodes its own address window. The window index sits in the address bits above `WIN_BITS`, and it must equal the `CHAN_ID` parameter. The low byte of the address selects the register. Interrupt sources gather in a raw register. That register is filtered by a mask and cleared through a write-one-to-clear acknowledge register, and the filtered result drives one level-sensitive interrupt line.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the status word reads 0x101, the state output is 1 (RST), every other register reads 0, and `irq` and `cmd_err` are low.
- R2: Registers at offsets 0x00, 0x58, 0x5C, 0x60, 0x7C, 0x80, 0x84, 0x8C and 0x9C read back the last written word. Read data and `bus_rvalid` appear in the cycle after the request. Offsets 0x90 (acknowledge), 0x94 (raw) and 0x98 (masked) read as described in R4/R5. Writes to 0x94, 0x98, 0x88 and any unmapped offset are ignored, and unmapped offsets read 0.
- R3: A write to config 0x84 with bit 0 clear sets the state to RST (1). Otherwise, if bit 1 is set, it sets the state to STOPPED (2). Otherwise the state is unchanged. Status 0x88 carries the state in bits [2:0], the end-of-list flag in bit 5 and the stream source (1) in bits [15:8].
- R4: Each `eng_intr_set` bit sets the matching raw interrupt bit. A write to acknowledge clears the raw bits that are written as 1, but a set in the same cycle wins. Acknowledge always reads 0.
- R5: The masked register reads raw AND mask. `irq` is high exactly when that value is nonzero, and it follows in the same cycle that the raw or mask register changes.
- R6: A stream-command write to 0x9C with any of bits 0x140 set pulses `eng_load_data` for one cycle. If bit 0x20 is also set, the state becomes RUNNING (4). Bit 0x200 pulses `eng_load_ctx`.
- R7: `eng_eol_set` sets the end-of-list flag. A stream start clears it, but an `eng_eol_set` in the same cycle wins.
- R8: A command write to 0x80 with bit 0 set pulses `eng_continue` only when config bit 0 is 1, config bit 1 is 0, the state is RUNNING and `eng_descr_eol` is high.
- R9: A command write with any bit above bit 0 set, or a stream-command write with any bit above bit 9 set, sets the sticky `cmd_err` flag. The written value is still stored.
- R10: A request whose `bus_size` is not 2'b10 (a word) pulses `bus_err`. It changes no register and gives no `bus_rvalid`.
- R11: A request whose address bits above `WIN_BITS` differ from `CHAN_ID` is ignored: no effect, no `bus_rvalid`, no `bus_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size; 2'b10 is a word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| bus_err | output | 1 | Sub-word access rejected |
| eng_intr_set | input | INTR_W | Interrupt set events from the engine |
| eng_eol_set | input | 1 | Engine reached end of list |
| eng_descr_eol | input | 1 | Current data descriptor has its end-of-list bit |
| eng_load_data | output | 1 | Pulse: load data descriptor |
| eng_load_ctx | output | 1 | Pulse: load context descriptor |
| eng_continue | output | 1 | Pulse: continue request accepted |
| chan_state | output | 3 | Channel state, 1/2/4 |
| irq | output | 1 | Level interrupt |
| cmd_err | output | 1 | Sticky illegal-command flag |

## Verification
Two functions can land in the same clock edge. One is a bus write to the acknowledge register while the engine raises the same interrupt bit. The other is a stream start while the engine reports end of list. The bench provokes both by driving the engine input during the cycle of the bus write. It then judges the result by reading the raw register, or the end-of-list bit of the status word, back through the bus: the engine event must have survived in both cases.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

    localparam int DATA_W  = 32;
    localparam int NUM_SEL = 13;

    localparam int SEL_DATA  = 0;
    localparam int SEL_SAVED = 1;
    localparam int SEL_SBUF  = 2;
    localparam int SEL_GRP   = 3;
    localparam int SEL_GDOWN = 4;
    localparam int SEL_CMD   = 5;
    localparam int SEL_CFG   = 6;
    localparam int SEL_STAT  = 7;
    localparam int SEL_MASK  = 8;
    localparam int SEL_ACK   = 9;
    localparam int SEL_RAW   = 10;
    localparam int SEL_MSKD  = 11;
    localparam int SEL_STRM  = 12;

    // byte offsets inside a channel window, indexed by SEL_*
    localparam logic [7:0] REG_OFFS [NUM_SEL] = '{
        8'h00, 8'h58, 8'h5C, 8'h60, 8'h7C, 8'h80, 8'h84,
        8'h88, 8'h8C, 8'h90, 8'h94, 8'h98, 8'h9C
    };

    localparam logic [1:0] SIZE_WORD = 2'b10;

    localparam logic [9:0] STRM_LOAD_D = 10'h140;
    localparam logic [9:0] STRM_BURST  = 10'h020;
    localparam logic [9:0] STRM_LOAD_C = 10'h200;

    typedef enum logic [2:0] {
        ST_RST  = 3'd1,
        ST_STOP = 3'd2,
        ST_RUN  = 3'd4
    } chan_state_e;

endpackage

// File: rtl/dma_bus_decode.sv
module dma_bus_decode
    import dma_regs_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int WIN_BITS = 13,
    parameter int CHAN_ID  = 1
) (
    input  logic              bus_req,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              acc_ok,
    output logic              acc_bad,
    output logic [NUM_SEL-1:0] sel
);

    localparam int CH_W = ADDR_W - WIN_BITS;
    localparam logic [CH_W-1:0] CH_VAL = CH_W'(CHAN_ID);

    logic chan_hit;
    logic upper_zero;

    assign chan_hit   = bus_req && (bus_addr[ADDR_W-1:WIN_BITS] == CH_VAL);
    assign upper_zero = (bus_addr[WIN_BITS-1:8] == '0);
    assign acc_ok     = chan_hit && (bus_size == SIZE_WORD);
    assign acc_bad    = chan_hit && (bus_size != SIZE_WORD);

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        assign sel[g] = upper_zero && (bus_addr[7:0] == REG_OFFS[g]);
    end

endmodule

// File: rtl/dma_stream_decode.sv
module dma_stream_decode
    import dma_regs_pkg::*;
(
    input  logic              valid,
    input  logic [DATA_W-1:0] value,
    output logic              load_d,
    output logic              load_c,
    output logic              start,
    output logic              illegal
);

    logic [9:0] field;

    assign field   = value[9:0];
    assign load_d  = valid && ((field & STRM_LOAD_D) != '0);
    assign start   = load_d && ((field & STRM_BURST) != '0);
    assign load_c  = valid && ((field & STRM_LOAD_C) != '0);
    assign illegal = valid && (value[DATA_W-1:10] != '0);

endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit
    import dma_regs_pkg::*;
#(
    parameter int INTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic              ack_we,
    input  logic [INTR_W-1:0] wdata,
    input  logic [INTR_W-1:0] set_in,
    output logic [INTR_W-1:0] raw_q,
    output logic [INTR_W-1:0] mask_q,
    output logic              irq_q
);

    typedef struct packed {
        logic [INTR_W-1:0] raw;
        logic [INTR_W-1:0] mask;
        logic              irq;
    } irq_regs_t;

    irq_regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (ack_we) begin
            r_d.raw = r_q.raw & ~wdata;
        end
        r_d.raw = r_d.raw | set_in;   // new events win over acknowledge
        if (mask_we) begin
            r_d.mask = wdata;
        end
        r_d.irq = |(r_d.raw & r_d.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign raw_q  = r_q.raw;
    assign mask_q = r_q.mask;
    assign irq_q  = r_q.irq;

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_regs_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int WIN_BITS   = 13,
    parameter int CHAN_ID    = 1,
    parameter int INTR_W     = 4,
    parameter int STREAM_SRC = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_err,
    input  logic [INTR_W-1:0] eng_intr_set,
    input  logic              eng_eol_set,
    input  logic              eng_descr_eol,
    output logic              eng_load_data,
    output logic              eng_load_ctx,
    output logic              eng_continue,
    output logic [2:0]        chan_state,
    output logic              irq,
    output logic              cmd_err
);

    typedef struct packed {
        logic [DATA_W-1:0] data_ptr;
        logic [DATA_W-1:0] saved;
        logic [DATA_W-1:0] sbuf;
        logic [DATA_W-1:0] grp;
        logic [DATA_W-1:0] gdown;
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] cfg;
        logic [DATA_W-1:0] strm;
        chan_state_e       state;
        logic              eol;
        logic              cmd_err;
        logic              load_d;
        logic              load_c;
        logic              cont;
        logic              rvalid;
        logic              berr;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t q, d;

    logic               acc_ok, acc_bad;
    logic [NUM_SEL-1:0] sel;
    logic               wr, rd;
    logic               st_load_d, st_load_c, st_start, st_bad;
    logic [INTR_W-1:0]  irq_raw, irq_mask;
    logic               irq_line;
    logic [DATA_W-1:0]  rd_vals [NUM_SEL];
    logic [DATA_W-1:0]  rd_word;

    dma_bus_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS),
        .CHAN_ID  (CHAN_ID)
    ) i_decode (
        .bus_req  (bus_req),
        .bus_size (bus_size),
        .bus_addr (bus_addr),
        .acc_ok   (acc_ok),
        .acc_bad  (acc_bad),
        .sel      (sel)
    );

    assign wr = acc_ok && bus_we;
    assign rd = acc_ok && !bus_we;

    dma_stream_decode i_stream (
        .valid   (wr && sel[SEL_STRM]),
        .value   (bus_wdata),
        .load_d  (st_load_d),
        .load_c  (st_load_c),
        .start   (st_start),
        .illegal (st_bad)
    );

    dma_irq_unit #(
        .INTR_W (INTR_W)
    ) i_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (wr && sel[SEL_MASK]),
        .ack_we  (wr && sel[SEL_ACK]),
        .wdata   (bus_wdata[INTR_W-1:0]),
        .set_in  (eng_intr_set),
        .raw_q   (irq_raw),
        .mask_q  (irq_mask),
        .irq_q   (irq_line)
    );

    // read sources, one per select line
    always_comb begin
        rd_vals[SEL_DATA]  = q.data_ptr;
        rd_vals[SEL_SAVED] = q.saved;
        rd_vals[SEL_SBUF]  = q.sbuf;
        rd_vals[SEL_GRP]   = q.grp;
        rd_vals[SEL_GDOWN] = q.gdown;
        rd_vals[SEL_CMD]   = q.cmd;
        rd_vals[SEL_CFG]   = q.cfg;
        rd_vals[SEL_STAT]  = {16'h0, 8'(STREAM_SRC), 2'b00, q.eol, 2'b00, q.state};
        rd_vals[SEL_MASK]  = DATA_W'(irq_mask);
        rd_vals[SEL_ACK]   = '0;
        rd_vals[SEL_RAW]   = DATA_W'(irq_raw);
        rd_vals[SEL_MSKD]  = DATA_W'(irq_raw & irq_mask);
        rd_vals[SEL_STRM]  = q.strm;
        rd_word = '0;
        for (int i = 0; i < NUM_SEL; i++) begin
            if (sel[i]) begin
                rd_word = rd_word | rd_vals[i];
            end
        end
    end

    always_comb begin
        d        = q;
        d.load_d = 1'b0;
        d.load_c = 1'b0;
        d.cont   = 1'b0;
        d.rvalid = rd;
        d.berr   = acc_bad;
        d.rdata  = rd ? rd_word : '0;

        if (wr) begin
            if (sel[SEL_DATA])  d.data_ptr = bus_wdata;
            if (sel[SEL_SAVED]) d.saved    = bus_wdata;
            if (sel[SEL_SBUF])  d.sbuf     = bus_wdata;
            if (sel[SEL_GRP])   d.grp      = bus_wdata;
            if (sel[SEL_GDOWN]) d.gdown    = bus_wdata;
            if (sel[SEL_CMD]) begin
                d.cmd = bus_wdata;
                if (bus_wdata[DATA_W-1:1] != '0) begin
                    d.cmd_err = 1'b1;
                end
                if (bus_wdata[0] && q.cfg[0] && !q.cfg[1] &&
                    (q.state == ST_RUN) && eng_descr_eol) begin
                    d.cont = 1'b1;
                end
            end
            if (sel[SEL_CFG]) begin
                d.cfg = bus_wdata;
                if (!bus_wdata[0]) begin
                    d.state = ST_RST;
                end else if (bus_wdata[1]) begin
                    d.state = ST_STOP;
                end
            end
            if (sel[SEL_STRM]) begin
                d.strm   = bus_wdata;
                d.load_d = st_load_d;
                d.load_c = st_load_c;
                if (st_bad) begin
                    d.cmd_err = 1'b1;
                end
                if (st_start) begin
                    d.state = ST_RUN;
                    d.eol   = 1'b0;
                end
            end
        end

        if (eng_eol_set) begin
            d.eol = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_RST;
        end else begin
            q <= d;
        end
    end

    assign bus_rdata     = q.rdata;
    assign bus_rvalid    = q.rvalid;
    assign bus_err       = q.berr;
    assign eng_load_data = q.load_d;
    assign eng_load_ctx  = q.load_c;
    assign eng_continue  = q.cont;
    assign chan_state    = q.state;
    assign irq           = irq_line;
    assign cmd_err       = q.cmd_err;

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
    parameter int INTR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [1:0]        bus_size,
    input logic              bus_rvalid,
    input logic              bus_err,
    input logic              eng_load_data,
    input logic              eng_load_ctx,
    input logic              eng_continue,
    input logic [2:0]        chan_state,
    input logic              cmd_err,
    input logic              irq,
    input logic [INTR_W-1:0] raw,
    input logic [INTR_W-1:0] mask
);

    AST_STATE_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(chan_state) == 1); // R3

    AST_IRQ_FOLLOWS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (|(raw & mask))); // R5

    AST_LOAD_DATA_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_load_data |-> $past(bus_req && bus_we && bus_size == 2'b10)); // R6

    AST_LOAD_CTX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        eng_load_ctx |-> $past(bus_req && bus_we && bus_size == 2'b10)); // R6

    AST_CONTINUE_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        eng_continue |-> $past(chan_state) == 3'd4); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err); // R9

    AST_SUBWORD_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (!bus_rvalid && $past(bus_size) != 2'b10)); // R10

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.INTR_W(INTR_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_size      (bus_size),
    .bus_rvalid    (bus_rvalid),
    .bus_err       (bus_err),
    .eng_load_data (eng_load_data),
    .eng_load_ctx  (eng_load_ctx),
    .eng_continue  (eng_continue),
    .chan_state    (chan_state),
    .cmd_err       (cmd_err),
    .irq           (irq),
    .raw           (irq_raw),
    .mask          (irq_mask)
);

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;

    localparam int NV = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_size = 2'b10;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid, bus_err;
    logic [3:0]  eng_intr_set = '0;
    logic        eng_eol_set = 1'b0;
    logic        eng_descr_eol = 1'b0;
    logic        eng_load_data, eng_load_ctx, eng_continue;
    logic [2:0]  chan_state;
    logic        irq, cmd_err;

    int checks = 0;
    int errors = 0;

    logic        c_rvalid, c_err, c_ld, c_lc, c_cont;
    logic [31:0] c_rdata;

    dma_chan_regs i_dma_chan_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_req       (bus_req),
        .bus_we        (bus_we),
        .bus_size      (bus_size),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .bus_rvalid    (bus_rvalid),
        .bus_err       (bus_err),
        .eng_intr_set  (eng_intr_set),
        .eng_eol_set   (eng_eol_set),
        .eng_descr_eol (eng_descr_eol),
        .eng_load_data (eng_load_data),
        .eng_load_ctx  (eng_load_ctx),
        .eng_continue  (eng_continue),
        .chan_state    (chan_state),
        .irq           (irq),
        .cmd_err       (cmd_err)
    );

    always #10 clk = ~clk;

    // {address, write data, expected read-back}
    localparam logic [79:0] VEC [NV] = '{
        {16'h2000, 32'hA5A5_0001, 32'hA5A5_0001},
        {16'h2058, 32'h1234_5678, 32'h1234_5678},
        {16'h205C, 32'h0BAD_F00D, 32'h0BAD_F00D},
        {16'h2060, 32'h0000_6060, 32'h0000_6060},
        {16'h207C, 32'h7C7C_0000, 32'h7C7C_0000},
        {16'h2084, 32'h0000_0001, 32'h0000_0001},
        {16'h2080, 32'h0000_0001, 32'h0000_0001},
        {16'h208C, 32'h0000_000A, 32'h0000_000A},
        {16'h2090, 32'h0000_000F, 32'h0000_0000},
        {16'h209C, 32'h0000_0010, 32'h0000_0010},
        {16'h2094, 32'h0000_000F, 32'h0000_0000},
        {16'h2098, 32'h0000_000F, 32'h0000_0000},
        {16'h2040, 32'h0000_0005, 32'h0000_0000}
    };

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic bus_op(input logic we, input logic [1:0] size,
                          input logic [15:0] addr, input logic [31:0] wdata,
                          input logic [3:0] intr, input logic eol);
        @(negedge clk);
        bus_req      = 1'b1;
        bus_we       = we;
        bus_size     = size;
        bus_addr     = addr;
        bus_wdata    = wdata;
        eng_intr_set = intr;
        eng_eol_set  = eol;
        @(negedge clk);
        c_rvalid = bus_rvalid;
        c_rdata  = bus_rdata;
        c_err    = bus_err;
        c_ld     = eng_load_data;
        c_lc     = eng_load_ctx;
        c_cont   = eng_continue;
        bus_req      = 1'b0;
        bus_we       = 1'b0;
        bus_size     = 2'b10;
        eng_intr_set = '0;
        eng_eol_set  = 1'b0;
    endtask

    task automatic wr(input logic [15:0] addr, input logic [31:0] v);
        bus_op(1'b1, 2'b10, addr, v, 4'h0, 1'b0);
    endtask

    task automatic rd(input logic [15:0] addr);
        bus_op(1'b0, 2'b10, addr, 32'h0, 4'h0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1", "state", 32'(chan_state), 32'd1);
        chk("R1", "irq", 32'(irq), 32'd0);
        chk("R1", "cmd_err", 32'(cmd_err), 32'd0);
        rd(16'h2088);
        chk("R1", "status", c_rdata, 32'h101);
        rd(16'h2000);
        chk("R1", "data ptr", c_rdata, 32'h0);

        // R2 table walk
        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][79:64], VEC[i][63:32]);
            rd(VEC[i][79:64]);
            chk("R2", "rvalid", 32'(c_rvalid), 32'd1);
            chk("R2", "readback", c_rdata, VEC[i][31:0]);
        end

        // R10 sub-word write rejected
        bus_op(1'b1, 2'b01, 16'h2000, 32'hFFFF_FFFF, 4'h0, 1'b0);
        chk("R10", "bus_err", 32'(c_err), 32'd1);
        bus_op(1'b0, 2'b00, 16'h2000, 32'h0, 4'h0, 1'b0);
        chk("R10", "no rvalid", 32'(c_rvalid), 32'd0);
        rd(16'h2000);
        chk("R10", "unchanged", c_rdata, 32'hA5A5_0001);

        // R11 other channel window
        wr(16'h4000, 32'h1111_1111);
        chk("R11", "no err", 32'(c_err), 32'd0);
        rd(16'h4000);
        chk("R11", "no rvalid", 32'(c_rvalid), 32'd0);
        rd(16'h2000);
        chk("R11", "unchanged", c_rdata, 32'hA5A5_0001);

        // R3 config transitions
        wr(16'h2084, 32'h3);
        chk("R3", "stop", 32'(chan_state), 32'd2);
        rd(16'h2088);
        chk("R3", "status stop", c_rdata, 32'h102);
        wr(16'h2084, 32'h1);
        chk("R3", "hold", 32'(chan_state), 32'd2);
        wr(16'h2084, 32'h2);
        chk("R3", "reset wins", 32'(chan_state), 32'd1);

        // R6 stream commands
        wr(16'h209C, 32'h40);
        chk("R6", "load data", 32'(c_ld), 32'd1);
        chk("R6", "no ctx", 32'(c_lc), 32'd0);
        chk("R6", "no start", 32'(chan_state), 32'd1);
        wr(16'h209C, 32'h160);
        chk("R6", "load data burst", 32'(c_ld), 32'd1);
        chk("R6", "running", 32'(chan_state), 32'd4);
        wr(16'h209C, 32'h200);
        chk("R6", "load ctx", 32'(c_lc), 32'd1);
        chk("R6", "ctx only", 32'(c_ld), 32'd0);

        // R7 end-of-list flag
        bus_op(1'b0, 2'b10, 16'h2000, 32'h0, 4'h0, 1'b1);
        rd(16'h2088);
        chk("R7", "eol set", c_rdata, 32'h124);
        wr(16'h209C, 32'h120);
        rd(16'h2088);
        chk("R7", "start clears", c_rdata, 32'h104);
        bus_op(1'b1, 2'b10, 16'h209C, 32'h120, 4'h0, 1'b1);
        rd(16'h2088);
        chk("R7", "eol wins start", c_rdata, 32'h124);

        // R8 continue
        wr(16'h2084, 32'h1);
        chk("R8", "still running", 32'(chan_state), 32'd4);
        eng_descr_eol = 1'b0;
        wr(16'h2080, 32'h1);
        chk("R8", "no continue w/o descr eol", 32'(c_cont), 32'd0);
        eng_descr_eol = 1'b1;
        wr(16'h2080, 32'h1);
        chk("R8", "continue", 32'(c_cont), 32'd1);
        wr(16'h2084, 32'h3);
        wr(16'h2080, 32'h1);
        chk("R8", "no continue stopped", 32'(c_cont), 32'd0);
        eng_descr_eol = 1'b0;
        chk("R9", "no err yet", 32'(cmd_err), 32'd0);

        // R9 command error
        wr(16'h2080, 32'h2);
        chk("R9", "cmd err", 32'(cmd_err), 32'd1);
        rd(16'h2080);
        chk("R9", "cmd stored", c_rdata, 32'h2);

        // R4 / R5 interrupts
        wr(16'h208C, 32'h4);
        bus_op(1'b0, 2'b10, 16'h2094, 32'h0, 4'h4, 1'b0);
        chk("R5", "irq on", 32'(irq), 32'd1);
        rd(16'h2098);
        chk("R5", "masked", c_rdata, 32'h4);
        bus_op(1'b0, 2'b10, 16'h2094, 32'h0, 4'h1, 1'b0);
        rd(16'h2094);
        chk("R4", "raw accum", c_rdata, 32'h5);
        wr(16'h208C, 32'h0);
        chk("R5", "irq masked off", 32'(irq), 32'd0);
        wr(16'h208C, 32'h5);
        chk("R5", "irq back", 32'(irq), 32'd1);
        wr(16'h2090, 32'h4);
        rd(16'h2094);
        chk("R4", "ack clears", c_rdata, 32'h1);
        chk("R5", "irq from bit0", 32'(irq), 32'd1);
        rd(16'h2090);
        chk("R4", "ack reads zero", c_rdata, 32'h0);
        wr(16'h2090, 32'h1);
        chk("R5", "irq off", 32'(irq), 32'd0);
        bus_op(1'b1, 2'b10, 16'h2090, 32'h2, 4'h2, 1'b0);
        rd(16'h2094);
        chk("R4", "set wins ack", c_rdata, 32'h2);
        rd(16'h2098);
        chk("R5", "masked filtered", c_rdata, 32'h0);

        // R9 stream error after fresh reset
        do_reset();
        chk("R1", "err cleared", 32'(cmd_err), 32'd0);
        wr(16'h209C, 32'h400);
        chk("R9", "stream err", 32'(cmd_err), 32'd1);
        chk("R9", "no load", 32'(c_ld), 32'd0);
        rd(16'h209C);
        chk("R9", "stream stored", c_rdata, 32'h400);

        finish_run();
    end

endmodule